// File: doc/BRIEF.md
# Four-Input Quorum Word Voter

This block arbitrates between four redundant copies of a data word. It does not count votes. Instead it tests a fixed family of three quorums: the pair (A,B), the triple (A,C,D) and the triple (B,C,D). When every member of a quorum holds the same word, that word becomes the voted result. Four equality comparators are enough to decide every quorum: A=B, A=C, C=D and B=C. A two-way multiplexer between A and B then forms the result. The family behaves like a weighted vote in which A and B carry weight 2, C and D carry weight 1, and a value needs a total weight of at least 4 to win.

A caller presents the four words with a one-cycle valid strobe. On the next clock edge the block registers four things: the voted word, a no-quorum flag, a one-hot code naming the quorum that decided, and an output valid pulse. When several quorums agree at once, a fixed priority picks one: the pair first, then (A,C,D), then (B,C,D). When no quorum agrees, the output word reads zero and the quorum code is cleared. The registered results hold while no new strobe arrives.

Top module: `quorum_word_voter`

## Requirements
- R1: While reset is asserted and after it is released, with no strobe seen, out_valid, out_word, no_quorum and quorum_hit all read zero.
- R2: out_valid is high in exactly the cycle after each cycle in which in_valid was sampled high, and low otherwise.
- R3: If word_a equals word_b, the registered result is word_a and quorum_hit is 3'b001 (bit 0 = pair A,B). This holds whatever C and D hold.
- R4: If word_a, word_c and word_d are equal and word_b differs, the result is word_a and quorum_hit is 3'b010 (bit 1 = triple A,C,D).
- R5: If word_b, word_c and word_d are equal, word_a differs from word_b and word_a differs from word_c, the result is word_b and quorum_hit is 3'b100 (bit 2 = triple B,C,D).
- R6: If no quorum agrees, no_quorum reads 1, out_word reads zero and quorum_hit reads 3'b000.
- R7: While in_valid is low, out_word, no_quorum and quorum_hit keep their last registered values, whatever the data inputs do.
- R8: A quorum is found exactly when some input value gathers a weight of at least 4, with weights 2,2,1,1 for A,B,C,D. The voted word is that value.
- R9: quorum_hit is never more than one-hot, and no_quorum is high exactly when quorum_hit is zero after a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Strobe: sample the four words on this edge |
| word_a | input | DATA_W | Copy A (weight 2) |
| word_b | input | DATA_W | Copy B (weight 2) |
| word_c | input | DATA_W | Copy C (weight 1) |
| word_d | input | DATA_W | Copy D (weight 1) |
| out_valid | output | 1 | Result registered this cycle |
| out_word | output | DATA_W | Voted word, zero when no quorum |
| no_quorum | output | 1 | No quorum set agreed |
| quorum_hit | output | 3 | One-hot deciding quorum: bit0 pair A,B; bit1 A,C,D; bit2 B,C,D |

## Verification
The functions that share a cycle are the three quorum tests. With all four words equal, or with A=B while C=D also matches A, two or three quorums are satisfied on the same edge. The priority must then pick exactly one. The bench provokes this with all-equal words and with A=B=C=D where only C and D are reused from A, and expects quorum_hit 3'b001 and word_a. An exhaustive sweep over a three-symbol alphabet for each input judges every other overlap against a weight-tally model of its own.

// File: rtl/qv_pkg.sv
package qv_pkg;

  localparam int NUM_WORDS = 4;
  localparam int NUM_CMP   = 4;
  localparam int NUM_SETS  = 3;

  // Position of each quorum in the one-hot code; also its priority rank.
  typedef enum logic [1:0] {
    SET_PAIR_AB  = 2'd0,
    SET_TRI_ACD  = 2'd1,
    SET_TRI_BCD  = 2'd2
  } quorum_e;

  // Comparator slots: 0 = A:B, 1 = A:C, 2 = C:D, 3 = B:C
  function automatic int cmp_lhs(input int slot);
    case (slot)
      0: return 0;
      1: return 0;
      2: return 2;
      default: return 1;
    endcase
  endfunction

  function automatic int cmp_rhs(input int slot);
    case (slot)
      0: return 1;
      1: return 2;
      2: return 3;
      default: return 2;
    endcase
  endfunction

  // Quorum agreement from the comparator results, unprioritised.
  function automatic logic [NUM_SETS-1:0] quorum_raw(input logic [NUM_CMP-1:0] eq);
    logic [NUM_SETS-1:0] r;
    r[SET_PAIR_AB] = eq[0];
    r[SET_TRI_ACD] = eq[1] & eq[2];
    r[SET_TRI_BCD] = eq[3] & eq[2];
    return r;
  endfunction

  // Lowest set bit wins.
  function automatic logic [NUM_SETS-1:0] pick_first(input logic [NUM_SETS-1:0] raw);
    logic [NUM_SETS-1:0] r;
    r = '0;
    for (int i = NUM_SETS - 1; i >= 0; i--) begin
      if (raw[i]) r = NUM_SETS'(1) << i;
    end
    return r;
  endfunction

endpackage

// File: rtl/qv_compare.sv
module qv_compare
  import qv_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [NUM_WORDS-1:0][DATA_W-1:0] words,
  output logic [NUM_CMP-1:0]               eq
);

  for (genvar s = 0; s < NUM_CMP; s++) begin : g_cmp
    localparam int L = cmp_lhs(s);
    localparam int R = cmp_rhs(s);
    assign eq[s] = (words[L] == words[R]);
  end

endmodule

// File: rtl/qv_decide.sv
module qv_decide
  import qv_pkg::*;
(
  input  logic [NUM_CMP-1:0]  eq,
  output logic [NUM_SETS-1:0] hit,
  output logic                sel_b,
  output logic                none
);

  logic [NUM_SETS-1:0] raw;

  always_comb begin
    raw   = quorum_raw(eq);
    hit   = pick_first(raw);
    none  = (raw == '0);
    sel_b = hit[SET_TRI_BCD];
  end

endmodule

// File: rtl/qv_outreg.sv
module qv_outreg
  import qv_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [DATA_W-1:0]   word_d,
  input  logic                none_d,
  input  logic [NUM_SETS-1:0] hit_d,
  output logic                valid_q,
  output logic [DATA_W-1:0]   word_q,
  output logic                none_q,
  output logic [NUM_SETS-1:0] hit_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      word_q  <= '0;
      none_q  <= 1'b0;
      hit_q   <= '0;
    end else begin
      valid_q <= load;
      if (load) begin
        word_q <= word_d;
        none_q <= none_d;
        hit_q  <= hit_d;
      end
    end
  end

endmodule

// File: rtl/quorum_word_voter.sv
module quorum_word_voter
  import qv_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] word_a,
  input  logic [DATA_W-1:0] word_b,
  input  logic [DATA_W-1:0] word_c,
  input  logic [DATA_W-1:0] word_d,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_word,
  output logic              no_quorum,
  output logic [2:0]        quorum_hit
);

  logic [NUM_WORDS-1:0][DATA_W-1:0] words;
  logic [NUM_CMP-1:0]               cmp_eq;
  logic [NUM_SETS-1:0]              next_hit;
  logic                             next_sel_b;
  logic                             next_none;
  logic [DATA_W-1:0]                next_word;

  assign words = {word_d, word_c, word_b, word_a};

  qv_compare #(.DATA_W(DATA_W)) u_cmp (
    .words (words),
    .eq    (cmp_eq)
  );

  qv_decide u_dec (
    .eq    (cmp_eq),
    .hit   (next_hit),
    .sel_b (next_sel_b),
    .none  (next_none)
  );

  always_comb begin
    if (next_none)       next_word = '0;
    else if (next_sel_b) next_word = word_b;
    else                 next_word = word_a;
  end

  qv_outreg #(.DATA_W(DATA_W)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (in_valid),
    .word_d  (next_word),
    .none_d  (next_none),
    .hit_d   (next_hit),
    .valid_q (out_valid),
    .word_q  (out_word),
    .none_q  (no_quorum),
    .hit_q   (quorum_hit)
  );

endmodule

// File: rtl/quorum_word_voter_chk.sv
module quorum_word_voter_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [DATA_W-1:0] word_a,
  input logic [DATA_W-1:0] word_b,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_word,
  input logic              no_quorum,
  input logic [2:0]        quorum_hit
);

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);  // R2

  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);  // R2

  AST_PAIR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && word_a == word_b) |=> (quorum_hit == 3'b001 && out_word == $past(word_a)));  // R3

  AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    no_quorum |-> (out_word == '0 && quorum_hit == 3'b000));  // R6

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_word) && $stable(no_quorum) && $stable(quorum_hit)));  // R7

  AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(quorum_hit));  // R9

  AST_FLAG_MATCHES_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (no_quorum == (quorum_hit == 3'b000)));  // R9

endmodule

bind quorum_word_voter quorum_word_voter_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .word_a     (word_a),
  .word_b     (word_b),
  .out_valid  (out_valid),
  .out_word   (out_word),
  .no_quorum  (no_quorum),
  .quorum_hit (quorum_hit)
);

// File: tb/quorum_word_voter_test.sv
module quorum_word_voter_test;

  localparam int W      = 16;
  localparam int CLK_NS = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [W-1:0] word_a = '0, word_b = '0, word_c = '0, word_d = '0;
  logic         out_valid;
  logic [W-1:0] out_word;
  logic         no_quorum;
  logic [2:0]   quorum_hit;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  quorum_word_voter #(.DATA_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .word_a(word_a), .word_b(word_b), .word_c(word_c), .word_d(word_d),
    .out_valid(out_valid), .out_word(out_word),
    .no_quorum(no_quorum), .quorum_hit(quorum_hit)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Present one strobe at a falling edge, sample after the next rising edge.
  task automatic vote(input logic [W-1:0] a, b, c, d);
    @(negedge clk);
    word_a = a; word_b = b; word_c = c; word_d = d;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_result(input string req, input logic [W-1:0] w, input logic nq, input logic [2:0] h);
    check(out_valid == 1'b1, {req, " valid"}, 32'(out_valid), 32'd1);
    check(out_word == w && no_quorum == nq && quorum_hit == h, req,
          {out_word, 12'd0, no_quorum, quorum_hit}, {w, 12'd0, nq, h});
  endtask

  task automatic t_reset();
    check(out_valid == 0 && out_word == 0 && no_quorum == 0 && quorum_hit == 0,
          "R1 reset state", {out_word, 12'd0, no_quorum, quorum_hit}, 32'd0);
  endtask

  task automatic t_pair();
    vote(16'h1234, 16'h1234, 16'h0001, 16'h0002);
    expect_result("R3 pair agrees", 16'h1234, 1'b0, 3'b001);
    vote(16'h00AA, 16'h00AA, 16'h00AA, 16'h00AA);
    expect_result("R3 all equal priority", 16'h00AA, 1'b0, 3'b001);
    vote(16'h5555, 16'h5555, 16'h5555, 16'h5555);
    expect_result("R3 overlapping sets", 16'h5555, 1'b0, 3'b001);
  endtask

  task automatic t_tri_acd();
    vote(16'hBEEF, 16'h0BAD, 16'hBEEF, 16'hBEEF);
    expect_result("R4 triple A,C,D", 16'hBEEF, 1'b0, 3'b010);
  endtask

  task automatic t_tri_bcd();
    vote(16'h0BAD, 16'hCAFE, 16'hCAFE, 16'hCAFE);
    expect_result("R5 triple B,C,D", 16'hCAFE, 1'b0, 3'b100);
  endtask

  task automatic t_none();
    vote(16'h0001, 16'h0002, 16'h0001, 16'h0002);
    expect_result("R6 split 2-2", 16'h0000, 1'b1, 3'b000);
    vote(16'h0011, 16'h0022, 16'h0033, 16'h0044);
    expect_result("R6 all distinct", 16'h0000, 1'b1, 3'b000);
    vote(16'hFFFF, 16'h0000, 16'h7777, 16'h7777);
    expect_result("R6 only C,D agree", 16'h0000, 1'b1, 3'b000);
  endtask

  task automatic t_valid_and_hold();
    vote(16'h4242, 16'h4242, 16'h0, 16'h0);
    expect_result("R2 strobe", 16'h4242, 1'b0, 3'b001);
    word_a = 16'h0001; word_b = 16'h0002; word_c = 16'h0003; word_d = 16'h0004;
    @(negedge clk);
    check(out_valid == 1'b0, "R2 no strobe no valid", 32'(out_valid), 32'd0);
    word_a = 16'h9999; word_b = 16'h8888;
    @(negedge clk);
    check(out_word == 16'h4242 && no_quorum == 0 && quorum_hit == 3'b001, "R7 hold while idle",
          {out_word, 12'd0, no_quorum, quorum_hit}, {16'h4242, 12'd0, 1'b0, 3'b001});
  endtask

  function automatic int tally(input logic [W-1:0] v, input logic [W-1:0] a, b, c, d);
    return (a == v ? 2 : 0) + (b == v ? 2 : 0) + (c == v ? 1 : 0) + (d == v ? 1 : 0);
  endfunction

  task automatic t_sweep();
    for (int i = 0; i < 81; i++) begin
      logic [W-1:0] a, b, c, d, ew;
      logic [2:0]   eh;
      logic         en;
      a = W'(16'h3000 + (i % 3));
      b = W'(16'h3000 + ((i / 3) % 3));
      c = W'(16'h3000 + ((i / 9) % 3));
      d = W'(16'h3000 + ((i / 27) % 3));
      en = 1'b0;
      if (a == b)                       begin ew = a; eh = 3'b001; end
      else if (tally(a, a, b, c, d) >= 4) begin ew = a; eh = 3'b010; end
      else if (tally(b, a, b, c, d) >= 4) begin ew = b; eh = 3'b100; end
      else                              begin ew = '0; eh = 3'b000; en = 1'b1; end
      vote(a, b, c, d);
      expect_result("R8 weight sweep", ew, en, eh);
      check($countones(quorum_hit) <= 1, "R9 onehot", 32'(quorum_hit), 32'(eh));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pair();
    t_tri_acd();
    t_tri_bcd();
    t_none();
    t_valid_and_hold();
    t_sweep();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule